// File: doc/BRIEF.md
# Block-Lookahead Fuzzy Grade Operator

This unit applies one of the three basic fuzzy-logic operators to a pair of membership grades. A grade is an unsigned WIDTH-bit word in which all-zeros means no membership and all-ones means full membership. The opcode selects one of three results:

- the larger grade (fuzzy union);
- the smaller grade (fuzzy intersection);
- the complement of A (fuzzy negation). Because of the grade encoding, the complement is the bitwise inverse of A.

No subtractor and no ripple comparator are used. The word is split into blocks of BLK bits. Each block reduces its per-bit equality and less-than flags into a group-equal and a group-less-than signal. A lookahead network then computes, for every block, the "equal so far" and "A smaller so far" decisions from all more significant blocks at once. Inside each block the same lookahead produces, for every bit, a decision term that steers the bit multiplexer toward A or B.

The result is registered once when OUT_REG is set, which is the default. The unit is intended as a building block for rule evaluation in fuzzy controllers and inference engines.

Top module: `fuzzy_op_unit`

## Requirements
- R1: With op_i = 2'b01, res_o equals the numerically smaller of a_i and b_i.
- R2: With op_i = 2'b00, res_o equals the numerically larger of a_i and b_i; for an 8-bit build, 8'b10011001 and 8'b11010001 give 8'b11010001.
- R3: When a_i equals b_i, both op_i = 2'b00 and op_i = 2'b01 return that same value.
- R4: With op_i = 2'b10, res_o equals the bitwise complement of a_i, and b_i has no effect on res_o (for example 4'b0010 gives 4'b1101).
- R5: op_i = 2'b11 is reserved and gives an all-zero res_o, whatever the operands.
- R6: The comparison is decided by the most significant differing bit, even when that bit lies in a more significant block than other differing bits (for example, MIN of 16'h1FFF and 16'h2000 is 16'h1FFF).
- R7: With OUT_REG = 1, res_o reflects the inputs sampled at the previous rising clock edge. While rst_ni is low, res_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Grade A |
| b_i | input | WIDTH | Grade B |
| op_i | input | 2 | Operator: 00 larger, 01 smaller, 10 complement of A, 11 reserved |
| res_o | output | WIDTH | Operator result |

## Verification
The bound checker compares every registered result against an arithmetic compare of the sampled operands, on every cycle, for each opcode. It also checks the zero output under reset. These cycle-by-cycle checks catch any lookahead term that picks the wrong operand.

Only the bench scenarios show the following:
- full coverage of all operand pairs in the reduced 8-bit build;
- the specific block-boundary cases;
- that the result does not appear before the clock edge.

// File: rtl/fzo_pkg.sv
package fzo_pkg;
  typedef enum logic [1:0] {
    FZ_MAX = 2'b00,
    FZ_MIN = 2'b01,
    FZ_INV = 2'b10,
    FZ_RSV = 2'b11
  } fz_op_e;
endpackage

// File: rtl/fzo_blk_cmp.sv
// One block: group equal / group less-than plus per-bit A-smaller decisions
module fzo_blk_cmp #(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] a_i,
  input  logic [BLK-1:0] b_i,
  input  logic           eq_in_i,   // all more significant blocks equal
  input  logic           lt_in_i,   // A already smaller above this block
  output logic           grp_eq_o,
  output logic           grp_lt_o,
  output logic [BLK-1:0] sel_a_o    // per bit: A is the smaller operand
);
  logic [BLK-1:0] z, y, lt_loc;

  assign z = ~(a_i ^ b_i);
  assign y = ~a_i & b_i;

  // lookahead inside the block: each bit looks at all bits at or above it
  always_comb begin
    for (int i = 0; i < BLK; i++) begin
      logic c, g;
      c = 1'b1;
      g = 1'b0;
      for (int k = BLK-1; k >= i; k--) begin
        g = g | (c & y[k]);
        c = c & z[k];
      end
      lt_loc[i] = g;
    end
  end

  assign grp_eq_o = &z;
  assign grp_lt_o = lt_loc[0];
  assign sel_a_o  = {BLK{lt_in_i}} | ({BLK{eq_in_i}} & lt_loc);
endmodule

// File: rtl/fzo_lookahead.sv
// Block-level lookahead: every block gets its entry decision directly
module fzo_lookahead #(
  parameter int NB = 4
) (
  input  logic [NB-1:0] grp_eq_i,
  input  logic [NB-1:0] grp_lt_i,
  output logic [NB-1:0] eq_in_o,
  output logic [NB-1:0] lt_in_o
);
  always_comb begin
    for (int k = 0; k < NB; k++) begin
      logic c, g;
      c = 1'b1;
      g = 1'b0;
      for (int j = NB-1; j > k; j--) begin
        g = g | (c & grp_lt_i[j]);
        c = c & grp_eq_i[j];
      end
      eq_in_o[k] = c;
      lt_in_o[k] = g;
    end
  end
endmodule

// File: rtl/fuzzy_op_unit.sv
module fuzzy_op_unit
  import fzo_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter int BLK     = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] res_o
);
  localparam int NB = WIDTH / BLK;

  if (WIDTH % BLK != 0) begin : g_bad_cfg
    $error("WIDTH must be a multiple of BLK");
  end

  logic [NB-1:0]    grp_eq, grp_lt, eq_in, lt_in;
  logic [WIDTH-1:0] sel_a, res_d;

  for (genvar n = 0; n < NB; n++) begin : g_blk
    fzo_blk_cmp #(.BLK(BLK)) u_blk (
      .a_i      (a_i[n*BLK +: BLK]),
      .b_i      (b_i[n*BLK +: BLK]),
      .eq_in_i  (eq_in[n]),
      .lt_in_i  (lt_in[n]),
      .grp_eq_o (grp_eq[n]),
      .grp_lt_o (grp_lt[n]),
      .sel_a_o  (sel_a[n*BLK +: BLK])
    );
  end

  fzo_lookahead #(.NB(NB)) u_la (
    .grp_eq_i (grp_eq),
    .grp_lt_i (grp_lt),
    .eq_in_o  (eq_in),
    .lt_in_o  (lt_in)
  );

  always_comb begin
    unique case (fz_op_e'(op_i))
      FZ_MIN:  res_d = (sel_a & a_i) | (~sel_a & b_i);
      FZ_MAX:  res_d = (sel_a & b_i) | (~sel_a & a_i);
      FZ_INV:  res_d = ~a_i;
      default: res_d = '0;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_o <= '0;
      else         res_o <= res_d;
    end
  end else begin : g_comb
    assign res_o = res_d;
  end
endmodule

// File: rtl/fzo_chk.sv
module fzo_chk #(
  parameter int WIDTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] res_o
);
  if (OUT_REG) begin : g_chk
    logic past_ok;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
    end

    // R1 R6
    min_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == 2'b01 |->
        res_o == (($past(a_i) < $past(b_i)) ? $past(a_i) : $past(b_i)));

    // R2 R6
    max_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == 2'b00 |->
        res_o == (($past(a_i) > $past(b_i)) ? $past(a_i) : $past(b_i)));

    // R3
    equal_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && !$past(op_i[1]) && $past(a_i) == $past(b_i) |->
        res_o == $past(a_i));

    // R4
    inv_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == 2'b10 |-> (res_o ^ $past(a_i)) == '1);

    // R5
    rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(op_i) == 2'b11 |-> res_o == '0);

    // R7
    reset_zero_chk: assert property (@(posedge clk_i)
      !rst_ni |-> res_o == '0);
  end
endmodule

bind fuzzy_op_unit fzo_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .a_i    (a_i),
  .b_i    (b_i),
  .op_i   (op_i),
  .res_o  (res_o)
);

// File: tb/sim_fuzzy_op_unit.sv
module sim_fuzzy_op_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0, res16;
  logic [1:0]  op16 = 2'b00;
  logic [7:0]  a8 = '0, b8 = '0, res8;
  logic [1:0]  op8 = 2'b00;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  fuzzy_op_unit #(.WIDTH(16), .BLK(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .op_i(op16), .res_o(res16));
  fuzzy_op_unit #(.WIDTH(8), .BLK(4)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .op_i(op8), .res_o(res8));

  function automatic logic [15:0] model(logic [1:0] op, logic [15:0] a, logic [15:0] b);
    case (op)
      2'b00:   return (a > b) ? a : b;
      2'b01:   return (a < b) ? a : b;
      2'b10:   return ~a;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run16(logic [1:0] op, logic [15:0] a, logic [15:0] b, string req);
    @(negedge clk);
    op16 = op; a16 = a; b16 = b;
    @(posedge clk); #1;
    check(req, res16, model(op, a, b));
  endtask

  task automatic run8(logic [1:0] op, logic [7:0] a, logic [7:0] b, string req);
    logic [15:0] e;
    @(negedge clk);
    op8 = op; a8 = a; b8 = b;
    @(posedge clk); #1;
    e = model(op, {8'h00, a}, {8'h00, b});
    if (op == 2'b10) e = {8'h00, ~a};
    check(req, {8'h00, res8}, e);
  endtask

  // {op, a, b, expected}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {2'b00, 16'h0099, 16'h00D1, 16'h00D1},  // R2
    {2'b01, 16'h0099, 16'h00D1, 16'h0099},  // R1
    {2'b01, 16'h1FFF, 16'h2000, 16'h1FFF},  // R6
    {2'b00, 16'h1FFF, 16'h2000, 16'h2000},  // R6
    {2'b01, 16'h8000, 16'h7FFF, 16'h7FFF},  // R6
    {2'b00, 16'h00F1, 16'h00EF, 16'h00F1},  // R6
    {2'b01, 16'h5A5A, 16'h5A5A, 16'h5A5A},  // R3
    {2'b00, 16'h5A5A, 16'h5A5A, 16'h5A5A},  // R3
    {2'b10, 16'h0002, 16'h0000, 16'hFFFD},  // R4
    {2'b10, 16'h0F0F, 16'h1234, 16'hF0F0},  // R4 b ignored
    {2'b11, 16'hFFFF, 16'hFFFF, 16'h0000},  // R5
    {2'b11, 16'h1234, 16'h0001, 16'h0000}   // R5
  };
  localparam string VREQ [NV] = '{"R2", "R1", "R6", "R6", "R6", "R6",
                                  "R3", "R3", "R4", "R4", "R5", "R5"};

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R7 reset holds zero despite active inputs
    a16 = 16'hABCD; b16 = 16'h1234; op16 = 2'b10;
    repeat (3) @(posedge clk);
    #1 check("R7", res16, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    for (int t = 0; t < NV; t++) begin
      logic [49:0] v;
      @(negedge clk);
      v = VEC[t];
      op16 = v[49:48]; a16 = v[47:32]; b16 = v[31:16];
      @(posedge clk); #1;
      check(VREQ[t], res16, v[15:0]);
    end

    // R7 latency: new input invisible before the edge
    run16(2'b01, 16'h0003, 16'h0007, "R1");
    @(negedge clk);
    op16 = 2'b10; a16 = 16'h00FF;
    #1 check("R7", res16, 16'h0003);
    @(posedge clk); #1 check("R7", res16, 16'hFF00);

    // R4 b has no effect: same a, different b
    run16(2'b10, 16'h3C3C, 16'hFFFF, "R4");
    run16(2'b10, 16'h3C3C, 16'h0000, "R4");

    // R2 directed 8-bit example
    run8(2'b00, 8'b10011001, 8'b11010001, "R2");

    // R1 R2 R6 exhaustive on 8-bit / 4-bit build
    for (int i = 0; i < 65536; i++) run8(2'b01, i[15:8], i[7:0], "R1");
    for (int i = 0; i < 65536; i++) run8(2'b00, i[15:8], i[7:0], "R2");

    // R1 R2 R4 R5 random on 16-bit build
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      logic [1:0]  ro;
      ra = 16'($urandom);
      rb = (i % 5 == 0) ? ra ^ 16'($urandom_range(0, 15)) : 16'($urandom);
      ro = 2'($urandom);
      run16(ro, ra, rb, "R1_R2_R4_R5");
    end

    // R7 reset clears a nonzero result
    run16(2'b10, 16'h0000, 16'h0000, "R4");
    @(negedge clk) rst_n = 1'b0;
    #1 check("R7", res16, 16'h0000);
    @(negedge clk) rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule